// File: doc/BRIEF.md
# Window-Select Barrel Shifter

This block shifts or rotates an operand by any amount in a single pass of combinational logic. It does not use a chain of log2 multiplexer stages. It places the operand and zeros into the two halves of a double-width source word. It then reads out one contiguous operand-wide slice of that word, using a one-hot column select that has one bit per possible slice offset. The pattern used to fill the two halves sets the operation.

A thin control stage turns a two-bit operation code and a binary shift amount into two fill strobes and the one-hot column vector. An output register, enabled by a parameter, captures the result and an error flag for timing closure.

The slice core checks its column vector. If the vector is empty or has more than one bit set, the core raises the error flag and drives zeros. The reserved operation code produces an empty vector, so it exercises this check at the ports.

Top module: `barrel_shifter`

## Requirements
- R1: Operation code 0 (logical right): one cycle after the inputs are presented, `resData` equals `operand` shifted right by `shiftAmt` with zeros entering at the top.
- R2: Operation code 1 (logical left): one cycle after the inputs, `resData` equals `operand` shifted left by `shiftAmt` with zeros entering at the bottom.
- R3: Operation code 2 (rotate right): one cycle after the inputs, `resData` equals `operand` rotated toward bit 0 by `shiftAmt`, so bit i of the result is operand bit (i + shiftAmt) mod WIDTH.
- R4: A `shiftAmt` of zero returns `operand` unchanged under codes 0, 1 and 2.
- R5: Operation code 3 is reserved. It leaves the column select empty, so one cycle later `selErr` is 1 and `resData` is all zeros, whatever the operand and amount.
- R6: Under codes 0, 1 and 2, `selErr` is 0 one cycle later, for every shift amount.
- R7: Every result and error flag is due exactly one clock edge after its inputs, and back-to-back inputs give back-to-back results with no bubbles.
- R8: While `rstN` is low, `resData` is zero and `selErr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset |
| operand | input | WIDTH | Value to shift or rotate |
| shiftAmt | input | $clog2(WIDTH) | Binary shift amount |
| opCode | input | 2 | 0 right, 1 left, 2 rotate right, 3 reserved |
| resData | output | WIDTH | Registered shift result |
| selErr | output | 1 | Registered flag: column select was not one-hot |

## Verification
With the default registered output, every result and error flag is due one clock edge after the inputs that produced it. Nothing else in the block adds delay. The driver applies a new input set on each falling edge and queues the value that the requirements predict. The monitor compares the queue head a short time after the next rising edge, so each expected item meets the output of the edge that captured its inputs. The bench sweeps all sixteen amounts in all three valid operation codes over several operand patterns, then applies the reserved code. Inputs change on every cycle, so a stale or one-cycle-late output fails the comparison.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

  typedef enum logic [1:0] {
    OP_SHR = 2'd0,
    OP_SHL = 2'd1,
    OP_ROR = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  // Strobes from the control stage to the slice datapath
  typedef struct packed {
    logic hiFromOp;   // upper half of the source word carries the operand
    logic loFromOp;   // lower half of the source word carries the operand
    logic colValid;   // a column select was produced at all
  } fill_t;

endpackage

// File: rtl/barrel_ctrl.sv
module barrel_ctrl
  import barrel_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SW   = $clog2(WIDTH),
  localparam int COLS = WIDTH + 1,
  localparam int IW   = $clog2(COLS)
) (
  input  logic [SW-1:0]   shiftAmt,
  input  logic [1:0]      opCode,
  output fill_t           fill,
  output logic [COLS-1:0] colSel
);

  logic [IW-1:0] colIdx;

  // The source word is {upper, lower}; the slice at column k is src[k +: WIDTH].
  always_comb begin
    fill   = '0;
    colIdx = '0;
    unique case (op_e'(opCode))
      OP_SHR: begin
        fill.loFromOp = 1'b1;
        fill.colValid = 1'b1;
        colIdx        = IW'(shiftAmt);
      end
      OP_SHL: begin
        fill.hiFromOp = 1'b1;
        fill.colValid = 1'b1;
        colIdx        = IW'(WIDTH) - IW'(shiftAmt);
      end
      OP_ROR: begin
        fill.hiFromOp = 1'b1;
        fill.loFromOp = 1'b1;
        fill.colValid = 1'b1;
        colIdx        = IW'(shiftAmt);
      end
      default: begin
        fill = '0;
      end
    endcase
  end

  for (genvar c = 0; c < COLS; c++) begin : g_dec
    assign colSel[c] = fill.colValid && (colIdx == IW'(c));
  end

endmodule

// File: rtl/barrel_window.sv
module barrel_window
  import barrel_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int COLS = WIDTH + 1
) (
  input  logic [WIDTH-1:0] operand,
  input  fill_t            fill,
  input  logic [COLS-1:0]  colSel,
  output logic [WIDTH-1:0] sliceOut,
  output logic             sliceErr
);

  logic [2*WIDTH-1:0] srcWord;
  logic [WIDTH-1:0]   colTap [COLS];
  logic               multiHot;

  assign srcWord = {fill.hiFromOp ? operand : '0,
                    fill.loFromOp ? operand : '0};

  // One gated tap per column; only the enabled column passes its slice
  for (genvar k = 0; k < COLS; k++) begin : g_col
    assign colTap[k] = srcWord[k +: WIDTH] & {WIDTH{colSel[k]}};
  end

  assign multiHot = |(colSel & (colSel - COLS'(1)));
  assign sliceErr = multiHot || (colSel == '0);

  always_comb begin
    sliceOut = '0;
    for (int k = 0; k < COLS; k++) begin
      sliceOut = sliceOut | colTap[k];
    end
    if (sliceErr) sliceOut = '0;
  end

endmodule

// File: rtl/barrel_outreg.sv
module barrel_outreg #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             errIn,
  output logic [WIDTH-1:0] dOut,
  output logic             errOut
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dOut   <= '0;
        errOut <= 1'b0;
      end else begin
        dOut   <= dIn;
        errOut <= errIn;
      end
    end
  end else begin : g_pass
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
    assign dOut   = dIn;
    assign errOut = errIn;
  end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import barrel_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int SW     = $clog2(WIDTH),
  localparam int COLS   = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] operand,
  input  logic [SW-1:0]    shiftAmt,
  input  logic [1:0]       opCode,
  output logic [WIDTH-1:0] resData,
  output logic             selErr
);

  fill_t            fill;
  logic [COLS-1:0]  colSel;
  logic [WIDTH-1:0] sliceOut;
  logic             sliceErr;

  barrel_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .shiftAmt (shiftAmt),
    .opCode   (opCode),
    .fill     (fill),
    .colSel   (colSel)
  );

  barrel_window #(.WIDTH(WIDTH)) u_window (
    .operand  (operand),
    .fill     (fill),
    .colSel   (colSel),
    .sliceOut (sliceOut),
    .sliceErr (sliceErr)
  );

  barrel_outreg #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_outreg (
    .clk    (clk),
    .rstN   (rstN),
    .dIn    (sliceOut),
    .errIn  (sliceErr),
    .dOut   (resData),
    .errOut (selErr)
  );

endmodule

// File: rtl/barrel_shifter_chk.sv
module barrel_shifter_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int SW     = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] operand,
  input logic [SW-1:0]    shiftAmt,
  input logic [1:0]       opCode,
  input logic [WIDTH-1:0] resData,
  input logic             selErr
);

  function automatic logic [WIDTH-1:0] rotRight(logic [WIDTH-1:0] v, logic [SW-1:0] s);
    logic [2*WIDTH-1:0] dbl;
    dbl = {v, v} >> s;
    return dbl[WIDTH-1:0];
  endfunction

  if (REG_OUT) begin : g_chk
    assert_shr_R1: assert property (@(posedge clk) disable iff (!rstN)
      (opCode == 2'd0) |=> (resData == ($past(operand) >> $past(shiftAmt))));

    assert_shl_R2: assert property (@(posedge clk) disable iff (!rstN)
      (opCode == 2'd1) |=> (resData == ($past(operand) << $past(shiftAmt))));

    assert_ror_R3: assert property (@(posedge clk) disable iff (!rstN)
      (opCode == 2'd2) |=> (resData == rotRight($past(operand), $past(shiftAmt))));

    assert_zero_amt_R4: assert property (@(posedge clk) disable iff (!rstN)
      (opCode != 2'd3 && shiftAmt == '0) |=> (resData == $past(operand)));

    assert_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
      (opCode == 2'd3) |=> (selErr && resData == '0));

    assert_no_err_R6: assert property (@(posedge clk) disable iff (!rstN)
      (opCode != 2'd3) |=> !selErr);

    assert_reset_R8: assert property (@(posedge clk)
      !rstN |=> (resData == '0 && !selErr));
  end

endmodule

bind barrel_shifter barrel_shifter_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .operand  (operand),
  .shiftAmt (shiftAmt),
  .opCode   (opCode),
  .resData  (resData),
  .selErr   (selErr)
);

// File: tb/barrel_shifter_bench.sv
module barrel_shifter_bench;

  localparam int WIDTH = 16;
  localparam int SW    = $clog2(WIDTH);

  typedef struct {
    logic [WIDTH-1:0] data;
    logic             err;
    string            tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [WIDTH-1:0] operand = '0;
  logic [SW-1:0]    shiftAmt = '0;
  logic [1:0]       opCode = 2'd0;
  logic [WIDTH-1:0] resData;
  logic             selErr;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sbq[$];

  always #4 clk = ~clk;

  barrel_shifter #(.WIDTH(WIDTH)) u_barrel_shifter (
    .clk      (clk),
    .rstN     (rstN),
    .operand  (operand),
    .shiftAmt (shiftAmt),
    .opCode   (opCode),
    .resData  (resData),
    .selErr   (selErr)
  );

  function automatic logic [WIDTH-1:0] refRor(logic [WIDTH-1:0] v, int s);
    logic [2*WIDTH-1:0] dbl;
    dbl = {v, v} >> s;
    return dbl[WIDTH-1:0];
  endfunction

  task automatic drive(input logic [WIDTH-1:0] op, input int s, input logic [1:0] code,
                       input string tag);
    exp_t e;
    @(negedge clk);
    operand  = op;
    shiftAmt = SW'(s);
    opCode   = code;
    e.err = 1'b0;
    case (code)
      2'd0: e.data = op >> s;
      2'd1: e.data = op << s;
      2'd2: e.data = refRor(op, s);
      default: begin
        e.data = '0;
        e.err  = 1'b1;
      end
    endcase
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: one item is due from each rising edge after it was driven (R7)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (resData !== e.data || selErr !== e.err) begin
          errors++;
          $display("FAIL %s R7: data=%h err=%b expected data=%h err=%b",
                   e.tag, resData, selErr, e.data, e.err);
        end
      end
    end
  end

  initial begin
    logic [WIDTH-1:0] pats [4];
    pats[0] = 16'hA5C3;
    pats[1] = 16'h8001;
    pats[2] = 16'hFFFF;
    pats[3] = 16'h1234;

    // R8: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (resData !== '0 || selErr !== 1'b0) begin
      errors++;
      $display("FAIL R8: data=%h err=%b expected data=0000 err=0", resData, selErr);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1, R2, R3, R4, R6: every amount, every valid code, several patterns
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < WIDTH; s++) begin
        drive(pats[p], s, 2'd0, (s == 0) ? "R4 R1 R6" : "R1 R6");
        drive(pats[p], s, 2'd1, (s == 0) ? "R4 R2 R6" : "R2 R6");
        drive(pats[p], s, 2'd2, (s == 0) ? "R4 R3 R6" : "R3 R6");
      end
    end

    // R5: reserved code, with varied operands and amounts
    drive(16'hFFFF, 0,  2'd3, "R5");
    drive(16'h5A5A, 7,  2'd3, "R5");
    drive(16'h0001, 15, 2'd3, "R5");
    // R5 then R6: the flag clears on the next valid input
    drive(16'hC001, 1,  2'd2, "R6 R3");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule